// File: doc/BRIEF.md
# SD Data FIFO Byte Packer

This block sits between a 32-bit host data register and a byte-wide card data port. A sixteen-word circular FIFO buffers the traffic in both directions. When the transfer direction is read, the block collects card bytes into words, least significant byte first, and pushes each finished word into the FIFO for the host to pop. When the direction is write, the block pops the words the host pushed and sends them to the card one byte at a time, low byte first.

A transfer counter sets how many bytes move. Writing the block-count register loads this counter with the block count times the byte-count register. The engine then moves at most one byte per clock and stops when the counter reaches zero. It stalls while the FIFO cannot take or give a word, or while the card has no byte ready. As side effects it sets the data flag and the data and block interrupt bits in a status register. It also forces a state field in a debug register to data mode when a transfer finishes, and shows the live FIFO fill level in that same debug register.

Top module: `sd_fifo_packer`

## Requirements
- R1: The FIFO holds 16 words. A host push to the data register (select code 0) while 16 words are held is dropped: the fill stays 16 and the dropped word never comes out.
- R2: A host read of the data register while the FIFO is empty returns 0 and leaves the fill at 0.
- R3: A write to the block-count register (select 3) loads the counter with block count times the byte-count register (select 2). Exactly that many bytes then cross the card port, and none move while the counter is zero.
- R4: When command bit 6 is 1 (read direction), a card byte is taken only in a cycle where card_rdy is high. The k-th byte of a word lands in bits 8k+7:8k.
- R5: If the counter reaches zero with 1 to 3 bytes collected, that partial word is pushed with its unfilled upper bytes zero.
- R6: When command bit 6 is 0 (write direction), each word is sent low byte first. Sending stops when the counter reaches zero, and unsent bytes of the last word are discarded.
- R7: Every word the engine pushes or pops sets status bit 0. Status bit 8 is also set when config bit 4 is 1.
- R8: When the counter reaches zero through a transfer step, debug bits 3:0 become 1. Status bit 9 is set only if command bit 7 and config bit 8 are both 1.
- R9: Debug bits 8:4 always read as the current FIFO fill count.
- R10: A debug-register write (select 4) whose bits 3:0 are 0xF stores 0 in that field. Any other value is stored as written.
- R11: Writing the status register (select 5) clears each status bit written as 1.
- R12: At most one byte crosses the card port per cycle. A read stalls while the FIFO is full, a write stalls while no word is available, and both resume without loss.
- R13: Select codes are 0 data, 1 config, 2 byte count, 3 block count, 4 debug, 5 status, 6 command. Config and the counts read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe (pops on data select) |
| host_addr | input | 3 | Register select code |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the selected register |
| card_rdy | input | 1 | Card has a byte ready |
| card_rx_data | input | 8 | Byte offered by the card |
| card_take | output | 1 | Offered byte consumed this cycle |
| card_tx_valid | output | 1 | Byte sent to card this cycle |
| card_tx_data | output | 8 | Byte sent to card |

## Verification
A lane-select or packing-count fault shows up as a wrong word at the very next host read of the data register after the transfer ends. A counter fault shows up as the wrong number of bytes on the card port, and as the debug state field switching to data mode too early or not at all. A fill-count or pointer fault appears at once in debug bits 8:4 and as reordered or lost words when the FIFO is drained. The full-FIFO and empty-FIFO stall tests expose stall faults within one word of the boundary.

// File: rtl/sdfp_pkg.sv
package sdfp_pkg;
   typedef enum logic [2:0] {
      SEL_DATA   = 3'd0,
      SEL_CFG    = 3'd1,
      SEL_BYTES  = 3'd2,
      SEL_BLOCKS = 3'd3,
      SEL_DEBUG  = 3'd4,
      SEL_STATUS = 3'd5,
      SEL_CMD    = 3'd6,
      SEL_NONE   = 3'd7
   } host_sel_e;

   localparam int CFG_DATA_IRQ_BIT  = 4;
   localparam int CFG_BLOCK_IRQ_BIT = 8;
   localparam int ST_W              = 10;
   localparam int ST_DATA_FLAG_BIT  = 0;
   localparam int ST_DATA_IRQ_BIT   = 8;
   localparam int ST_BLOCK_IRQ_BIT  = 9;
   localparam int CMD_W             = 16;
   localparam int CMD_RD_BIT        = 6;
   localparam int CMD_WR_BIT        = 7;
   localparam int STATE_W           = 4;
   localparam int FILL_LSB          = 4;
   localparam int FILL_W            = 5;
   localparam logic [STATE_W-1:0] STATE_PWRDN = 4'hF;
   localparam logic [STATE_W-1:0] STATE_DATA  = 4'h1;
endpackage

// File: rtl/sdfp_fifo.sv
module sdfp_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 32,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic [CW-1:0]    fill,
   output logic             full,
   output logic             empty
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      initial $fatal(1, "sdfp_fifo: DEPTH must be a power of two >= 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    rd_pos;
   logic [AW-1:0]    wr_idx;
   logic             push_ok;
   logic             pop_ok;

   assign full    = (fill == CW'(DEPTH));
   assign empty   = (fill == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign wr_idx  = rd_pos + fill[AW-1:0];
   assign head    = empty ? '0 : mem[rd_pos];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_idx] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pos <= '0;
         fill   <= '0;
      end else begin
         if (pop_ok) rd_pos <= rd_pos + AW'(1);
         case ({push_ok, pop_ok})
            2'b10:   fill <= fill + CW'(1);
            2'b01:   fill <= fill - CW'(1);
            default: fill <= fill;
         endcase
      end
   end
endmodule

// File: rtl/sdfp_engine.sv
module sdfp_engine #(
   parameter int CNT_W = 19,
   parameter int WIDTH = 32,
   localparam int NB = WIDTH / 8,
   localparam int BW = $clog2(NB)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dir_rd,
   input  logic             card_rdy,
   input  logic [7:0]       card_byte,
   input  logic             fifo_full,
   input  logic             fifo_empty,
   input  logic [WIDTH-1:0] fifo_head,
   output logic             fifo_push,
   output logic [WIDTH-1:0] fifo_wdata,
   output logic             fifo_pop,
   output logic             card_take,
   output logic             card_tx_valid,
   output logic [7:0]       card_tx_byte,
   output logic             word_evt,
   output logic             done_evt,
   output logic [CNT_W-1:0] remain
);
   if (WIDTH < 16 || (WIDTH % 8) != 0 || (NB & (NB - 1)) != 0) begin : g_bad_width
      initial $fatal(1, "sdfp_engine: WIDTH must be a power-of-two byte count >= 2 bytes");
   end

   logic [BW-1:0]    pk_n;
   logic [BW-1:0]    up_n;
   logic [WIDTH-1:0] pk_word;
   logic [WIDTH-1:0] up_word;
   logic [WIDTH-1:0] assembled;
   logic             active;
   logic             last;
   logic             rd_step;
   logic             wr_step;
   logic             word_end;

   for (genvar i = 0; i < NB; i++) begin : g_lane
      assign assembled[8*i +: 8] = (pk_n == BW'(i)) ? card_byte : pk_word[8*i +: 8];
   end

   assign active   = (remain != '0);
   assign last     = (remain == CNT_W'(1));
   assign rd_step  = active && dir_rd && card_rdy && !fifo_full;
   assign wr_step  = active && !dir_rd && ((up_n != '0) || !fifo_empty);
   assign word_end = (pk_n == BW'(NB - 1)) || last;

   assign fifo_push     = rd_step && word_end;
   assign fifo_wdata    = assembled;
   assign fifo_pop      = wr_step && (up_n == '0);
   assign card_take     = rd_step;
   assign card_tx_valid = wr_step;
   assign card_tx_byte  = (up_n == '0) ? fifo_head[7:0] : up_word[7:0];
   assign word_evt      = fifo_push || fifo_pop;
   assign done_evt      = (rd_step || wr_step) && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain  <= '0;
         pk_n    <= '0;
         pk_word <= '0;
         up_n    <= '0;
         up_word <= '0;
      end else if (load) begin
         remain  <= load_val;
         pk_n    <= '0;
         pk_word <= '0;
         up_n    <= '0;
         up_word <= '0;
      end else if (rd_step) begin
         remain <= remain - CNT_W'(1);
         if (word_end) begin
            pk_n    <= '0;
            pk_word <= '0;
         end else begin
            pk_n    <= pk_n + BW'(1);
            pk_word <= assembled;
         end
      end else if (wr_step) begin
         remain <= remain - CNT_W'(1);
         if (last) begin
            up_n <= '0;
         end else if (up_n == '0) begin
            up_n    <= BW'(NB - 1);
            up_word <= fifo_head >> 8;
         end else begin
            up_n    <= up_n - BW'(1);
            up_word <= up_word >> 8;
         end
      end
   end
endmodule

// File: rtl/sdfp_regs.sv
module sdfp_regs import sdfp_pkg::*; #(
   parameter int WIDTH    = 32,
   parameter int CFG_W    = 11,
   parameter int BYTES_W  = 10,
   parameter int BLOCKS_W = 9,
   parameter int DBG_W    = 22,
   parameter int FILL_CW  = 5,
   localparam int CNT_W   = BYTES_W + BLOCKS_W
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  host_sel_e           sel,
   input  logic [WIDTH-1:0]    wdata,
   input  logic                word_evt,
   input  logic                done_evt,
   input  logic [FILL_CW-1:0]  fill,
   output logic                load,
   output logic [CNT_W-1:0]    load_val,
   output logic                dir_rd,
   output logic [CFG_W-1:0]    cfg_q,
   output logic [CMD_W-1:0]    cmd_q,
   output logic [BYTES_W-1:0]  bytes_q,
   output logic [BLOCKS_W-1:0] blocks_q,
   output logic [ST_W-1:0]     status_q,
   output logic [DBG_W-1:0]    dbg_view
);
   logic [DBG_W-1:0] dbg_q;
   logic [ST_W-1:0]  st_set;
   logic [ST_W-1:0]  st_clr;

   assign load     = wr_en && (sel == SEL_BLOCKS);
   assign load_val = CNT_W'(wdata[BLOCKS_W-1:0]) * CNT_W'(bytes_q);
   assign dir_rd   = cmd_q[CMD_RD_BIT];

   always_comb begin
      st_set = '0;
      st_set[ST_DATA_FLAG_BIT] = word_evt;
      st_set[ST_DATA_IRQ_BIT]  = word_evt && cfg_q[CFG_DATA_IRQ_BIT];
      st_set[ST_BLOCK_IRQ_BIT] = done_evt && cmd_q[CMD_WR_BIT] && cfg_q[CFG_BLOCK_IRQ_BIT];
      st_clr = (wr_en && sel == SEL_STATUS) ? wdata[ST_W-1:0] : '0;
   end

   always_comb begin
      dbg_view = dbg_q;
      dbg_view[FILL_LSB +: FILL_W] = FILL_W'(fill);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         cmd_q    <= '0;
         bytes_q  <= '0;
         blocks_q <= '0;
         status_q <= '0;
         dbg_q    <= '0;
      end else begin
         status_q <= (status_q & ~st_clr) | st_set;
         if (wr_en) begin
            case (sel)
               SEL_CFG:    cfg_q    <= wdata[CFG_W-1:0];
               SEL_CMD:    cmd_q    <= {1'b0, wdata[CMD_W-2:0]};
               SEL_BYTES:  bytes_q  <= wdata[BYTES_W-1:0];
               SEL_BLOCKS: blocks_q <= wdata[BLOCKS_W-1:0];
               SEL_DEBUG: begin
                  dbg_q <= wdata[DBG_W-1:0];
                  if (wdata[STATE_W-1:0] == STATE_PWRDN) dbg_q[STATE_W-1:0] <= '0;
               end
               default: ;
            endcase
         end
         if (done_evt) dbg_q[STATE_W-1:0] <= STATE_DATA;
      end
   end
endmodule

// File: rtl/sd_fifo_packer.sv
module sd_fifo_packer import sdfp_pkg::*; #(
   parameter int DEPTH    = 16,
   parameter int WIDTH    = 32,
   parameter int BYTES_W  = 10,
   parameter int BLOCKS_W = 9,
   parameter int CFG_W    = 11,
   parameter int DBG_W    = 22
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr_en,
   input  logic             host_rd_en,
   input  logic [2:0]       host_addr,
   input  logic [WIDTH-1:0] host_wdata,
   output logic [WIDTH-1:0] host_rdata,
   input  logic             card_rdy,
   input  logic [7:0]       card_rx_data,
   output logic             card_take,
   output logic             card_tx_valid,
   output logic [7:0]       card_tx_data
);
   localparam int FILL_CW = $clog2(DEPTH) + 1;
   localparam int CNT_W   = BYTES_W + BLOCKS_W;

   if (FILL_CW > FILL_W || DBG_W < FILL_LSB + FILL_W) begin : g_bad_fill
      initial $fatal(1, "sd_fifo_packer: fill count does not fit the debug field");
   end
   if (CFG_W <= CFG_BLOCK_IRQ_BIT || WIDTH < CMD_W || WIDTH < DBG_W || WIDTH < CFG_W) begin : g_bad_regs
      initial $fatal(1, "sd_fifo_packer: register widths inconsistent");
   end

   host_sel_e             sel;
   logic                  host_push;
   logic                  host_pop;
   logic                  eng_push;
   logic                  eng_pop;
   logic [WIDTH-1:0]      eng_wdata;
   logic [WIDTH-1:0]      fifo_head;
   logic [FILL_CW-1:0]    fill;
   logic                  fifo_full;
   logic                  fifo_empty;
   logic                  word_evt;
   logic                  done_evt;
   logic [CNT_W-1:0]      remain;
   logic                  load;
   logic [CNT_W-1:0]      load_val;
   logic                  dir_rd;
   logic [CFG_W-1:0]      cfg_q;
   logic [CMD_W-1:0]      cmd_q;
   logic [BYTES_W-1:0]    bytes_q;
   logic [BLOCKS_W-1:0]   blocks_q;
   logic [ST_W-1:0]       status_q;
   logic [DBG_W-1:0]      dbg_view;

   assign sel       = host_sel_e'(host_addr);
   assign host_push = host_wr_en && (sel == SEL_DATA);
   assign host_pop  = host_rd_en && (sel == SEL_DATA);

   sdfp_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (eng_push || host_push),
      .push_data (eng_push ? eng_wdata : host_wdata),
      .pop       (eng_pop || host_pop),
      .head      (fifo_head),
      .fill      (fill),
      .full      (fifo_full),
      .empty     (fifo_empty)
   );

   sdfp_engine #(.CNT_W(CNT_W), .WIDTH(WIDTH)) u_engine (
      .clk           (clk),
      .rst_n         (rst_n),
      .load          (load),
      .load_val      (load_val),
      .dir_rd        (dir_rd),
      .card_rdy      (card_rdy),
      .card_byte     (card_rx_data),
      .fifo_full     (fifo_full),
      .fifo_empty    (fifo_empty),
      .fifo_head     (fifo_head),
      .fifo_push     (eng_push),
      .fifo_wdata    (eng_wdata),
      .fifo_pop      (eng_pop),
      .card_take     (card_take),
      .card_tx_valid (card_tx_valid),
      .card_tx_byte  (card_tx_data),
      .word_evt      (word_evt),
      .done_evt      (done_evt),
      .remain        (remain)
   );

   sdfp_regs #(
      .WIDTH(WIDTH), .CFG_W(CFG_W), .BYTES_W(BYTES_W),
      .BLOCKS_W(BLOCKS_W), .DBG_W(DBG_W), .FILL_CW(FILL_CW)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (host_wr_en),
      .sel      (sel),
      .wdata    (host_wdata),
      .word_evt (word_evt),
      .done_evt (done_evt),
      .fill     (fill),
      .load     (load),
      .load_val (load_val),
      .dir_rd   (dir_rd),
      .cfg_q    (cfg_q),
      .cmd_q    (cmd_q),
      .bytes_q  (bytes_q),
      .blocks_q (blocks_q),
      .status_q (status_q),
      .dbg_view (dbg_view)
   );

   always_comb begin
      case (sel)
         SEL_DATA:   host_rdata = fifo_head;
         SEL_CFG:    host_rdata = WIDTH'(cfg_q);
         SEL_BYTES:  host_rdata = WIDTH'(bytes_q);
         SEL_BLOCKS: host_rdata = WIDTH'(blocks_q);
         SEL_DEBUG:  host_rdata = WIDTH'(dbg_view);
         SEL_STATUS: host_rdata = WIDTH'(status_q);
         SEL_CMD:    host_rdata = WIDTH'(cmd_q);
         default:    host_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sdfp_checker.sv
module sdfp_checker #(
   parameter int DEPTH = 16,
   parameter int CW    = 5,
   parameter int CNT_W = 19
)(
   input logic             clk,
   input logic             rst_n,
   input logic             card_rdy,
   input logic             card_take,
   input logic             card_tx_valid,
   input logic [CW-1:0]    fill,
   input logic [CNT_W-1:0] remain,
   input logic             load,
   input logic             word_evt,
   input logic             done_evt,
   input logic             st_flag,
   input logic [3:0]       dbg_state
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) int'(fill) <= DEPTH); // R1
   AST_TAKE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n) card_take |-> card_rdy); // R4
   AST_ONE_SIDE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) !(card_take && card_tx_valid)); // R12
   AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (remain == '0) |-> (!card_take && !card_tx_valid)); // R3
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) ((card_take || card_tx_valid) && !load) |=> (remain == $past(remain) - CNT_W'(1))); // R3
   AST_DONE_STATE: assert property (@(posedge clk) disable iff (!rst_n) done_evt |=> (dbg_state == 4'h1)); // R8
   AST_DATA_FLAG: assert property (@(posedge clk) disable iff (!rst_n) word_evt |=> st_flag); // R7
   AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n) (int'(fill) - int'($past(fill)) <= 1) && (int'($past(fill)) - int'(fill) <= 1)); // R12
endmodule

bind sd_fifo_packer sdfp_checker #(.DEPTH(DEPTH), .CW(FILL_CW), .CNT_W(CNT_W)) u_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .card_rdy      (card_rdy),
   .card_take     (card_take),
   .card_tx_valid (card_tx_valid),
   .fill          (fill),
   .remain        (remain),
   .load          (load),
   .word_evt      (word_evt),
   .done_evt      (done_evt),
   .st_flag       (status_q[0]),
   .dbg_state     (dbg_view[3:0])
);

// File: tb/test_sd_fifo_packer.sv
module test_sd_fifo_packer;
   localparam logic [2:0] A_DATA = 3'd0, A_CFG = 3'd1, A_BYTES = 3'd2, A_BLOCKS = 3'd3,
                          A_DEBUG = 3'd4, A_STATUS = 3'd5, A_CMD = 3'd6;
   // {blocks, bytes per block, first card byte}
   localparam int NVEC = 6;
   localparam logic [23:0] VEC [NVEC] = '{
      {8'd1, 8'd4,  8'h10},
      {8'd1, 8'd5,  8'h20},
      {8'd2, 8'd3,  8'h30},
      {8'd1, 8'd1,  8'hF0},
      {8'd3, 8'd7,  8'hA0},
      {8'd4, 8'd16, 8'hFC}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr_en = 1'b0;
   logic        host_rd_en = 1'b0;
   logic [2:0]  host_addr = 3'd7;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        card_rdy = 1'b1;
   logic [7:0]  card_rx_data;
   logic        card_take;
   logic        card_tx_valid;
   logic [7:0]  card_tx_data;

   int          taken;
   int          tx_n;
   logic [7:0]  tx_buf [256];
   int          start_tk = 0;
   logic [7:0]  base_cur = '0;
   int          n_tests = 0;
   int          n_fail = 0;
   bit          done = 0;

   always #5 clk = ~clk;

   assign card_rx_data = base_cur + 8'(taken - start_tk);

   always @(posedge clk) begin
      if (!rst_n) begin
         taken <= 0;
         tx_n  <= 0;
      end else begin
         if (card_take) taken <= taken + 1;
         if (card_tx_valid) begin
            tx_buf[tx_n[7:0]] <= card_tx_data;
            tx_n <= tx_n + 1;
         end
      end
   end

   sd_fifo_packer i_sd_fifo_packer (
      .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .card_rdy(card_rdy), .card_rx_data(card_rx_data), .card_take(card_take),
      .card_tx_valid(card_tx_valid), .card_tx_data(card_tx_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      host_addr = a; host_wdata = d; host_wr_en = 1'b1;
      @(posedge clk); #1;
      host_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      host_addr = a; host_rd_en = 1'b1;
      #1 d = host_rdata;
      @(posedge clk); #1;
      host_rd_en = 1'b0;
   endtask

   task automatic pop_wait(output logic [31:0] d);
      logic [31:0] t;
      for (int i = 0; i < 40; i++) begin
         rd(A_DEBUG, t);
         if (t[8:4] != 0) break;
      end
      rd(A_DATA, d);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   function automatic logic [31:0] exp_word(input logic [7:0] base, input int n, input int k);
      logic [31:0] w = '0;
      for (int b = 0; b < 4; b++)
         if (4*k + b < n) w[8*b +: 8] = base + 8'(4*k + b);
      return w;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int mark;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // reset state
      rd(A_STATUS, d); chk("R7 status after reset", d, 32'h0);
      rd(A_DEBUG, d);  chk("R9 debug after reset", d, 32'h0);
      rd(A_DATA, d);   chk("R2 empty pop value", d, 32'h0);
      rd(A_DEBUG, d);  chk("R2 fill stays 0 after empty pop", {27'd0, d[8:4]}, 32'h0);

      // R13 register readback
      wr(A_CFG, 32'h7FF); rd(A_CFG, d); chk("R13 config readback", d, 32'h7FF);
      wr(A_BYTES, 32'h3); rd(A_BYTES, d); chk("R13 byte count readback", d, 32'h3);

      // table of read transfers (R3 R4 R5 R7 R8 R9)
      for (int v = 0; v < NVEC; v++) begin
         int blocks = int'(VEC[v][23:16]);
         int bpb    = int'(VEC[v][15:8]);
         int n      = blocks * bpb;
         int words  = (n + 3) / 4;
         wr(A_STATUS, 32'h3FF);
         wr(A_CMD, 32'h8040);
         wr(A_CFG, 32'h110);
         base_cur = VEC[v][7:0];
         start_tk = taken;
         wr(A_BYTES, 32'(bpb));
         wr(A_BLOCKS, 32'(blocks));
         wait_cyc(n + 3);
         chk("R3 bytes taken equals blocks*bytes", 32'(taken - start_tk), 32'(n));
         rd(A_DEBUG, d);
         chk("R9 fill after read transfer", {27'd0, d[8:4]}, 32'(words));
         chk("R8 state field data mode", {28'd0, d[3:0]}, 32'h1);
         rd(A_STATUS, d);
         chk("R7 R8 status after read (no block irq)", d, 32'h101);
         for (int k = 0; k < words; k++) begin
            rd(A_DATA, d);
            chk("R4 R5 packed word", d, exp_word(VEC[v][7:0], n, k));
         end
      end

      // R1 overflow, R2 underflow
      wr(A_CMD, 32'h0080);
      for (int i = 0; i < 17; i++) wr(A_DATA, 32'h1000 + i);
      rd(A_DEBUG, d); chk("R1 fill saturates at 16", {27'd0, d[8:4]}, 32'd16);
      for (int i = 0; i < 16; i++) begin
         rd(A_DATA, d); chk("R1 fifo order", d, 32'h1000 + i);
      end
      rd(A_DATA, d);  chk("R1 R2 dropped word absent, empty pop 0", d, 32'h0);
      rd(A_DEBUG, d); chk("R2 fill 0 after drain", {27'd0, d[8:4]}, 32'h0);

      // R6 write transfer with partial last word, block irq
      wr(A_STATUS, 32'h3FF);
      wr(A_CFG, 32'h110);
      wr(A_CMD, 32'h8080);
      wr(A_DATA, 32'h44332211);
      wr(A_DATA, 32'h88776655);
      wr(A_DATA, 32'hCCBBAA99);
      mark = tx_n;
      wr(A_BYTES, 32'd10);
      wr(A_BLOCKS, 32'd1);
      wait_cyc(14);
      chk("R6 bytes sent", 32'(tx_n - mark), 32'd10);
      for (int i = 0; i < 10; i++)
         chk("R6 byte order low first", {24'd0, tx_buf[8'(mark + i)]}, 32'h11 + 32'(i) * 32'h11);
      rd(A_DEBUG, d);  chk("R6 R9 leftover discarded, fill 0", {27'd0, d[8:4]}, 32'h0);
      chk("R8 state after write", {28'd0, d[3:0]}, 32'h1);
      rd(A_STATUS, d); chk("R8 block irq on write", d, 32'h301);

      // R7 R8 no irq bits when config enables clear
      wr(A_STATUS, 32'h3FF);
      wr(A_CFG, 32'h000);
      wr(A_DATA, 32'hDDCCBBAA);
      mark = tx_n;
      wr(A_BYTES, 32'd4);
      wr(A_BLOCKS, 32'd1);
      wait_cyc(8);
      chk("R6 four bytes sent", 32'(tx_n - mark), 32'd4);
      rd(A_STATUS, d); chk("R7 R8 only data flag when enables off", d, 32'h001);

      // R12 write stall on empty fifo, R3 product 2x2
      mark = tx_n;
      wr(A_BYTES, 32'd2);
      wr(A_BLOCKS, 32'd2);
      wait_cyc(10);
      chk("R12 no bytes while fifo empty", 32'(tx_n - mark), 32'd0);
      wr(A_DATA, 32'h0A0B0C0D);
      wait_cyc(6);
      chk("R12 R3 resumed bytes", 32'(tx_n - mark), 32'd4);
      chk("R12 first byte", {24'd0, tx_buf[8'(mark)]}, 32'h0D);
      chk("R12 last byte", {24'd0, tx_buf[8'(mark + 3)]}, 32'h0A);

      // R4 card not ready
      wr(A_CFG, 32'h110);
      wr(A_CMD, 32'h8040);
      card_rdy = 1'b0;
      base_cur = 8'h55;
      start_tk = taken;
      wr(A_BYTES, 32'd4);
      wr(A_BLOCKS, 32'd1);
      wait_cyc(10);
      chk("R4 nothing taken without ready", 32'(taken - start_tk), 32'd0);
      card_rdy = 1'b1;
      wait_cyc(8);
      rd(A_DATA, d); chk("R4 word after ready", d, 32'h58575655);

      // R12 read stalls on full fifo
      wr(A_STATUS, 32'h3FF);
      base_cur = 8'h00;
      start_tk = taken;
      wr(A_BYTES, 32'd80);
      wr(A_BLOCKS, 32'd1);
      wait_cyc(90);
      chk("R12 stalled at 64 bytes", 32'(taken - start_tk), 32'd64);
      rd(A_DEBUG, d); chk("R12 R1 fill 16 when stalled", {27'd0, d[8:4]}, 32'd16);
      for (int k = 0; k < 20; k++) begin
         pop_wait(d);
         chk("R12 word after stall", d, exp_word(8'h00, 80, k));
      end
      rd(A_DEBUG, d); chk("R12 drained", {27'd0, d[8:4]}, 32'h0);

      // R11 write-one-to-clear
      rd(A_STATUS, d); chk("R11 status before clear", d, 32'h101);
      wr(A_STATUS, 32'h001);
      rd(A_STATUS, d); chk("R11 clear bit 0 only", d, 32'h100);
      wr(A_STATUS, 32'h100);
      rd(A_STATUS, d); chk("R11 clear bit 8", d, 32'h0);

      // R10 debug write
      wr(A_DEBUG, 32'h30F);
      rd(A_DEBUG, d); chk("R10 0xF stores 0, fill bits live", d, 32'h200);
      wr(A_DEBUG, 32'h005);
      rd(A_DEBUG, d); chk("R10 plain value stored", d, 32'h005);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule